// File: doc/BRIEF.md
# ATA Programmed-I/O Transfer Sequencer

This block runs one register transfer on a parallel ATA device bus each time the host side raises a request. It latches the request's direction, the 4-bit register address and the 16-bit write data. It then steps the device-side strobes through four timed phases: address setup, active strobe, write hold and recovery. The length of each phase comes from an 8-bit cycle count on its own input. The host logic that owns the timing registers supplies these counts. At a 100 MHz clock the slowest standard mode uses 6, 28, 2 and 23 cycles.

The strobe phase can be stretched by the device's ready line when the enable input allows it. The ready line passes through a synchronizer first. Read data is taken from the data bus at the edge where the read strobe returns high. A one-cycle acknowledge then goes back to the host with that data. Writes drive the data bus from address setup until the hold phase ends. A new request is taken only after recovery has finished.

Top module: `ata_pio_engine`

## Requirements
- R1: During and straight after reset, both chip selects, both strobes and the acknowledge are inactive. The address lines, `dd_o`, `dd_oe` and `rdata` are all zero.
- R2: Address bit 3 picks the chip select: 1 asserts `cs1_n`, 0 asserts `cs0_n`. Bits 2:0 drive `da`. Both hold steady from the cycle after the request is taken until recovery ends. In idle both selects are high and `da` is 0.
- R3: The four phases last max(T,1) cycles each, using `t_setup`, `t_active`, `t_hold` and `t_recover` as they stand when the phase is entered. Setup begins in the cycle after the clock edge at which a request is seen in idle.
- R4: On a read (`we`=0), `dior_n` is low for the whole active phase. `rdata` takes `dd_i` as sampled at the clock edge that ends the active phase, and keeps it until the next read.
- R5: On a write (`we`=1), `diow_n` is low for the active phase. `dd_oe` is high and `dd_o` equals the latched write data from setup through hold. `dd_oe` is never high on a read, and `dd_o` is zero when not driven.
- R6: `ack` is high for exactly one cycle: the first cycle after the strobe returns high.
- R7: `req` is ignored from acceptance until recovery ends. With `req` held high, successive transfers start one cycle after each recovery ends.
- R8: With `iordy_en`=1, the active phase does not end at its count while the twice-synchronized `iordy` is low. It ends at the first edge at which the synchronized value is high.
- R9: With `iordy_en`=0, `iordy` has no effect on the length of the active phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Transfer request, sampled in idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Bit 3 chip-select choice, bits 2:0 device address |
| wdata | input | 16 | Write data |
| t_setup | input | 8 | Address setup length in cycles |
| t_active | input | 8 | Strobe pulse length in cycles |
| t_hold | input | 8 | Write hold length in cycles |
| t_recover | input | 8 | End-of-cycle recovery length in cycles |
| iordy_en | input | 1 | Allow the ready line to stretch the strobe |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read data |
| da | output | 3 | Device address lines |
| cs0_n | output | 1 | Command block select, active low |
| cs1_n | output | 1 | Control block select, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_o | output | 16 | Data bus output value |
| dd_oe | output | 1 | Data bus output enable |
| dd_i | input | 16 | Data bus input value |
| iordy | input | 1 | Device ready, asynchronous |

## Verification
Several properties are checked on every cycle:
- select and address lines stay steady while busy;
- the bus is never driven during a read strobe;
- write data is still driven in the cycle after the write strobe rises;
- the acknowledge is single and directly follows the strobe's end;
- a stalled strobe stays asserted.

Some behaviour only the bench scenarios can show, by comparing against a cycle-by-cycle reference:
- the exact phase lengths, including zero counts;
- the capture edge of read data against a bus value that changes every cycle;
- the two-cycle lag of the ready line;
- the spacing of back-to-back transfers under a held request.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_ACTIVE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RECOV  = 3'd4
  } pio_phase_e;

  // Slowest-mode defaults at a 100 MHz clock, in cycles.
  localparam int MODE0_SETUP   = 6;
  localparam int MODE0_ACTIVE  = 28;
  localparam int MODE0_HOLD    = 2;
  localparam int MODE0_RECOVER = 23;

endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expired
);
  localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

  // A zero length is treated as one cycle.
  function automatic logic [TW-1:0] preset(input logic [TW-1:0] n);
    return (n == '0) ? '0 : n - ONE;
  endfunction

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= preset(len);
    else if (cnt != '0)   cnt <= cnt - ONE;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ata_pio_drive.sv
module ata_pio_drive
  import ata_pio_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  localparam int DAW = AW - 1
) (
  input  pio_phase_e       ph,
  input  logic             xfer_we,
  input  logic [AW-1:0]    xfer_addr,
  input  logic [DW-1:0]    xfer_wdata,
  output logic [DAW-1:0]   da,
  output logic             cs0_n,
  output logic             cs1_n,
  output logic             dior_n,
  output logic             diow_n,
  output logic [DW-1:0]    dd_o,
  output logic             dd_oe
);
  logic busy, active, drive;

  always_comb begin
    busy   = (ph != PH_IDLE);
    active = (ph == PH_ACTIVE);
    drive  = xfer_we && (ph == PH_SETUP || ph == PH_ACTIVE || ph == PH_HOLD);
    da     = busy ? xfer_addr[DAW-1:0] : '0;
    cs0_n  = !(busy && !xfer_addr[AW-1]);
    cs1_n  = !(busy &&  xfer_addr[AW-1]);
    dior_n = !(active && !xfer_we);
    diow_n = !(active &&  xfer_we);
    dd_oe  = drive;
    dd_o   = drive ? xfer_wdata : '0;
  end
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int TW = 8,
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DAW = AW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [TW-1:0]   t_setup,
  input  logic [TW-1:0]   t_active,
  input  logic [TW-1:0]   t_hold,
  input  logic [TW-1:0]   t_recover,
  input  logic            iordy_en,
  output logic            ack,
  output logic [DW-1:0]   rdata,
  output logic [DAW-1:0]  da,
  output logic            cs0_n,
  output logic            cs1_n,
  output logic            dior_n,
  output logic            diow_n,
  output logic [DW-1:0]   dd_o,
  output logic            dd_oe,
  input  logic [DW-1:0]   dd_i,
  input  logic            iordy
);
  pio_phase_e     ph, ph_nxt;
  logic           xfer_we;
  logic [AW-1:0]  xfer_addr;
  logic [DW-1:0]  xfer_wdata;

  // Named internal events.
  logic           iordy_s;
  logic           expired;
  logic           tload;
  logic [TW-1:0]  tlen;
  logic           accept;
  logic           stall;
  logic           strobe_end;
  logic           busy;
  logic           strobe_on;

  ata_pio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(iordy), .q(iordy_s)
  );

  ata_pio_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .len(tlen), .expired(expired)
  );

  assign busy      = (ph != PH_IDLE);
  assign strobe_on = (ph == PH_ACTIVE);
  assign accept    = (ph == PH_IDLE) && req;
  assign stall     = iordy_en && !iordy_s;

  always_comb begin
    ph_nxt     = ph;
    tload      = 1'b0;
    tlen       = '0;
    strobe_end = 1'b0;
    unique case (ph)
      PH_IDLE: if (req) begin
        ph_nxt = PH_SETUP;  tload = 1'b1; tlen = t_setup;
      end
      PH_SETUP: if (expired) begin
        ph_nxt = PH_ACTIVE; tload = 1'b1; tlen = t_active;
      end
      PH_ACTIVE: if (expired && !stall) begin
        ph_nxt = PH_HOLD;   tload = 1'b1; tlen = t_hold; strobe_end = 1'b1;
      end
      PH_HOLD: if (expired) begin
        ph_nxt = PH_RECOV;  tload = 1'b1; tlen = t_recover;
      end
      PH_RECOV: if (expired) ph_nxt = PH_IDLE;
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      xfer_we    <= 1'b0;
      xfer_addr  <= '0;
      xfer_wdata <= '0;
      ack        <= 1'b0;
      rdata      <= '0;
    end else begin
      ph  <= ph_nxt;
      ack <= strobe_end;
      if (accept) begin
        xfer_we    <= we;
        xfer_addr  <= addr;
        xfer_wdata <= wdata;
      end
      if (strobe_end && !xfer_we) rdata <= dd_i;
    end
  end

  ata_pio_drive #(.AW(AW), .DW(DW)) u_drive (
    .ph(ph), .xfer_we(xfer_we), .xfer_addr(xfer_addr), .xfer_wdata(xfer_wdata),
    .da(da), .cs0_n(cs0_n), .cs1_n(cs1_n), .dior_n(dior_n), .diow_n(diow_n),
    .dd_o(dd_o), .dd_oe(dd_oe)
  );

  // R2: selects and address steady across a transfer
  a_r2_select_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({cs0_n, cs1_n, da}));

  // R5: bus never driven while the read strobe is low
  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !dior_n |-> !dd_oe);

  // R5: write data still driven after the write strobe rises
  a_r5_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(diow_n) |-> dd_oe);

  // R6: acknowledge follows the end of the strobe
  a_r6_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($past(strobe_on) && !strobe_on));

  // R6: acknowledge lasts a single cycle
  a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R7: recovery still pending after the acknowledge
  a_r7_busy_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> busy);

  // R8: a stalled strobe at its count stays asserted
  a_r8_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && expired && stall) |=> strobe_on);
endmodule

// File: tb/tb_ata_pio_engine.sv
module tb_ata_pio_engine;
  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, iordy_en = 0, iordy = 1;
  logic [3:0] addr = 0;
  logic [15:0] wdata = 0, dd_i = 0;
  logic [7:0] t1 = 6, t2 = 28, t4 = 2, t5 = 23;
  logic ack, cs0_n, cs1_n, dior_n, diow_n, dd_oe;
  logic [15:0] rdata, dd_o;
  logic [2:0] da;

  always #4 clk = ~clk;

  ata_pio_engine dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .t_setup(t1), .t_active(t2), .t_hold(t4), .t_recover(t5), .iordy_en(iordy_en),
    .ack(ack), .rdata(rdata), .da(da), .cs0_n(cs0_n), .cs1_n(cs1_n),
    .dior_n(dior_n), .diow_n(diow_n), .dd_o(dd_o), .dd_oe(dd_oe),
    .dd_i(dd_i), .iordy(iordy)
  );

  int checks = 0, fails = 0, cyc = 0;
  int mph = 0, spent = 0, s1 = 0, s2 = 0;
  int mwe = 0;
  logic [3:0] maddr = 0;
  logic [15:0] mwdata = 0, m_rdata = 0;
  int m_ack = 0;
  int cur_len = 0, last_len = 0, ack_cnt = 0, last_ack_cyc = 0, ack_gap = 0;
  bit cmp_on = 0;

  function automatic int lenf(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference, advanced on each rising edge.
  always @(posedge clk) begin
    int old_s2;
    cyc++;
    if (!rst_n) begin
      mph = 0; spent = 0; s1 = 0; s2 = 0; m_ack = 0; m_rdata = 0;
    end else begin
      old_s2 = s2; s2 = s1; s1 = iordy;
      m_ack = 0;
      case (mph)
        0: if (req) begin mph = 1; spent = 0; mwe = we; maddr = addr; mwdata = wdata; end
        1: begin spent++; if (spent >= lenf(t1)) begin mph = 2; spent = 0; end end
        2: begin
          spent++;
          if (spent >= lenf(t2) && !(iordy_en && old_s2 == 0)) begin
            mph = 3; spent = 0; m_ack = 1;
            if (!mwe) m_rdata = dd_i;
          end
        end
        3: begin spent++; if (spent >= lenf(t4)) begin mph = 4; spent = 0; end end
        4: begin spent++; if (spent >= lenf(t5)) begin mph = 0; spent = 0; end end
        default: mph = 0;
      endcase
    end
  end

  // Comparison away from the active edge.
  always @(negedge clk) begin
    bit busy_e, oe_e;
    if (cmp_on) begin
      busy_e = (mph != 0);
      oe_e = mwe && mph >= 1 && mph <= 3;
      chk(cs0_n == !(busy_e && !maddr[3]), "R2 cs0_n", cs0_n, !(busy_e && !maddr[3]));
      chk(cs1_n == !(busy_e && maddr[3]), "R2 cs1_n", cs1_n, !(busy_e && maddr[3]));
      chk(da == (busy_e ? maddr[2:0] : 3'd0), "R2 da", da, busy_e ? maddr[2:0] : 0);
      chk(dior_n == !(mph == 2 && !mwe), "R4 dior_n", dior_n, !(mph == 2 && !mwe));
      chk(diow_n == !(mph == 2 && mwe), "R5 diow_n", diow_n, !(mph == 2 && mwe));
      chk(dd_oe == oe_e, "R5 dd_oe", dd_oe, oe_e);
      chk(dd_o == (oe_e ? mwdata : 16'd0), "R5 dd_o", dd_o, oe_e ? mwdata : 0);
      chk(ack == m_ack, "R6 ack", ack, m_ack);
      chk(rdata == m_rdata, "R4 rdata", rdata, m_rdata);
      if (!dior_n || !diow_n) cur_len++;
      else if (cur_len > 0) begin last_len = cur_len; cur_len = 0; end
      if (ack) begin
        ack_cnt++; ack_gap = cyc - last_ack_cyc; last_ack_cyc = cyc;
      end
    end
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Bus value changes every cycle so the capture edge matters.
  always @(negedge clk) dd_i <= 16'hA000 + cyc[15:0];

  task automatic xfer(input bit w, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    we = w; addr = a; wdata = d; req = 1;
    @(negedge clk);
    req = 0;
    while (mph != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cs0_n && cs1_n, "R1 selects", {cs0_n, cs1_n}, 3);
    chk(dior_n && diow_n, "R1 strobes", {dior_n, diow_n}, 3);
    chk(!ack && !dd_oe, "R1 ack/oe", {ack, dd_oe}, 0);
    chk(da == 0 && dd_o == 0 && rdata == 0, "R1 data", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;

    // Mode-0 read on the command block
    t1 = 6; t2 = 28; t4 = 2; t5 = 23;
    xfer(0, 4'h7, 16'h0);
    chk(last_len == 28, "R3 active length mode0", last_len, 28);

    // Write on the control block
    t1 = 3; t2 = 4; t4 = 2; t5 = 5;
    xfer(1, 4'hA, 16'h5AA5);
    chk(last_len == 4, "R3 active length write", last_len, 4);

    // Zero counts
    t1 = 0; t2 = 0; t4 = 0; t5 = 0;
    xfer(0, 4'h9, 16'h0);
    chk(last_len == 1, "R3 zero length", last_len, 1);
    xfer(1, 4'h3, 16'hC3C3);
    chk(last_len == 1, "R3 zero length write", last_len, 1);

    // Ready stretch enabled
    t1 = 2; t2 = 3; t4 = 1; t5 = 2;
    iordy_en = 1; iordy = 0;
    fork
      xfer(0, 4'h2, 16'h0);
      begin repeat (12) @(negedge clk); iordy = 1; end
    join
    chk(last_len > 3, "R8 strobe stretched", last_len, 4);

    // Ready low but stretching disabled
    iordy_en = 0; iordy = 0;
    xfer(0, 4'hE, 16'h0);
    chk(last_len == 3, "R9 iordy ignored", last_len, 3);
    iordy = 1;

    // Held request: back-to-back spacing
    t1 = 1; t2 = 2; t4 = 1; t5 = 3;
    @(negedge clk);
    we = 1; addr = 4'h5; wdata = 16'h1234; req = 1;
    repeat (30) @(negedge clk);
    req = 0;
    chk(ack_gap == 8, "R7 transfer spacing", ack_gap, 8);
    while (mph != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule